// File: doc/BRIEF.md
# I2C Address Sweeper

This block is a self-running I2C controller that finds which devices are on the bus. After one start request it works through every 7-bit address from 0x01 up to 0x7F, one at a time. At each address it makes a short probe: a START condition, the address byte with the direction bit set to write, one acknowledge clock, then a STOP condition. No data bytes follow the address. Each address whose device pulls the data line low during the acknowledge clock gets a bit in a 128-bit presence map. A 7-bit counter keeps the number of devices found.

The controller drives both bus lines as open-drain outputs. Each output pin, when high, pulls its line low. The line values come back through input pins and pass through a synchroniser. A slave can stretch the clock by holding the clock line low. The controller waits while this happens, but only up to a limit set by a parameter. If the limit runs out, the controller gives up on that address, marks it absent, releases both lines and moves on. After each probe the controller waits out an idle gap, and the bus must be free before the next START.

A host pulses `start_i` while the block is idle. It then waits for the one-cycle `done_o` pulse and reads the map and the count.

Top module: `i2c_addr_sweeper`

## Requirements
- R1: One sweep probes addresses 0x01 to 0x7F in ascending order, each exactly once, which gives 127 START conditions. Address 0x00 is never probed, and its map bit (bit 0) stays 0 even if a device would answer there.
- R2: Each probe is one START, then the byte {address[6:0], 1'b0} sent most significant bit first, then one acknowledge clock, then one STOP. The STOP has its own clock rise, with the data line rising while the clock is high. No further clocks or data bytes follow. A probe that times out (R6) ends with no STOP.
- R3: Map bit n (present_o[n]) is 1 after the sweep only if the data line was low when the acknowledge (ninth) clock of address n was sampled while high. All other map bits read 0.
- R4: Inside a byte, including the acknowledge clock, the data line changes only while the clock line is low. The only data-line edges while the clock is high are START and STOP.
- R5: When a slave holds the clock line low during a high phase, the controller waits. It counts the full high time from the moment the line is seen high again. A stretched probe that is acknowledged is still reported present.
- R6: If the clock line stays low for STRETCH_MAX cycles during one high phase of a probe, the controller marks that address absent and releases both lines. It then goes on with the next address. If that address is 0x7F, the sweep ends instead.
- R7: Between a STOP and the next START, the bus stays idle for at least max(GAP_CYC, 2*HALF_CYC) cycles. Those cycles count only while both lines read high.
- R8: A start_i seen while busy_o is low is accepted at that clock edge. In the next cycle busy_o is 1, present_o is all zeros and found_o is 0.
- R9: A start_i seen while busy_o is high has no effect. The map is not cleared and the sweep neither restarts nor ends early.
- R10: busy_o stays high from acceptance until the sweep ends. It falls in the same cycle that done_o pulses high, and done_o stays high for exactly one cycle.
- R11: When done_o pulses, found_o equals the number of 1 bits in present_o. While busy, found_o never changes by more than +1 per cycle.
- R12: While reset is asserted, and after it, until a start is accepted: busy_o, done_o, both line-pull outputs, present_o and found_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Request a sweep; taken only while idle |
| busy_o | output | 1 | High for the whole sweep |
| done_o | output | 1 | One-cycle pulse when the sweep ends |
| present_o | output | 128 | Presence map, bit n for address n |
| found_o | output | 7 | Number of addresses that acknowledged |
| clk_line_i | input | 1 | Sensed level of the bus clock line |
| clk_line_low_o | output | 1 | 1 pulls the bus clock line low, 0 releases it |
| dat_line_i | input | 1 | Sensed level of the bus data line |
| dat_line_low_o | output | 1 | 1 pulls the bus data line low, 0 releases it |

## Verification
The start response is registered, so the bench drives start_i at a falling clock edge and checks busy_o, the cleared map and the zero count at the next falling edge, one core clock later. Bus-level results have no fixed latency, because of the synchroniser, clock stretching and the bus-free wait. The bench therefore decodes the bus with a slave model at every falling edge and compares event counts and ordering, not cycle positions. The gap check is a lower bound, since the synchroniser adds cycles to the gap but never removes any. Map, count and the done pulse are checked at the falling edge where done_o is first seen high, and the pulse width at the following falling edge.

// File: rtl/i2c_sweep_pkg.sv
package i2c_sweep_pkg;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned MAP_W  = 1 << ADDR_W;
  localparam int unsigned BITS_PER_PROBE = 9;

  typedef enum logic [2:0] {
    SW_IDLE,
    SW_GAP,
    SW_START,
    SW_LOW,
    SW_HIGH,
    SW_STOP_LOW,
    SW_STOP_HIGH
  } sweep_state_e;
endpackage

// File: rtl/sweep_sync.sv
module sweep_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = d;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sweep_cnt.sv
module sweep_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (clr)                 q_d = '0;
    else if (en && q != '1)  q_d = q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/sweep_presence.sv
module sweep_presence
  import i2c_sweep_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              set,
  input  logic [ADDR_W-1:0] idx,
  output logic [MAP_W-1:0]  map_q,
  output logic [ADDR_W-1:0] cnt_q
);
  logic [MAP_W-1:0]  map_d;
  logic [ADDR_W-1:0] cnt_d;

  always_comb begin
    map_d = map_q;
    cnt_d = cnt_q;
    if (clear) begin
      map_d = '0;
      cnt_d = '0;
    end else if (set) begin
      map_d[idx] = 1'b1;
      cnt_d      = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q <= '0;
      cnt_q <= '0;
    end else begin
      map_q <= map_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/sweep_fsm.sv
module sweep_fsm
  import i2c_sweep_pkg::*;
#(
  parameter int unsigned HALF_CYC    = 625,
  parameter int unsigned STRETCH_MAX = 12500,
  parameter int unsigned GAP_CYC     = 1250,
  parameter int unsigned TW          = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              ck_s,
  input  logic              dt_s,
  input  logic [TW-1:0]     ph_cnt,
  input  logic [TW-1:0]     st_cnt,
  output logic              ph_clr,
  output logic              st_clr,
  output logic              st_en,
  output logic              map_clr,
  output logic              hit,
  output logic [ADDR_W-1:0] hit_idx,
  output logic              ck_low_o,
  output logic              dt_low_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int unsigned GAP_EFF = (GAP_CYC < 2 * HALF_CYC) ? 2 * HALF_CYC : GAP_CYC;
  localparam logic [TW-1:0] HALF_END = TW'(HALF_CYC - 1);
  localparam logic [TW-1:0] HALF_MID = TW'(HALF_CYC / 2 - 1);
  localparam logic [TW-1:0] STR_END  = TW'(STRETCH_MAX - 1);
  localparam logic [TW-1:0] GAP_END  = TW'(GAP_EFF - 1);
  localparam logic [3:0]    ACK_BIT  = 4'(BITS_PER_PROBE - 1);

  sweep_state_e      state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [3:0]        bit_q, bit_d;
  logic              ck_q, ck_d;
  logic              dt_q, dt_d;
  logic              done_q, done_d;
  logic [7:0]        tx_byte;
  logic              abort;
  logic              in_high;

  assign tx_byte = {addr_q, 1'b0};
  assign in_high = (state_q == SW_HIGH) || (state_q == SW_STOP_HIGH);
  assign st_en   = in_high && !ck_s;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    bit_d   = bit_q;
    ck_d    = ck_q;
    dt_d    = dt_q;
    done_d  = 1'b0;
    ph_clr  = 1'b0;
    st_clr  = 1'b0;
    map_clr = 1'b0;
    hit     = 1'b0;
    abort   = 1'b0;
    unique case (state_q)
      SW_IDLE: begin
        ck_d   = 1'b0;
        dt_d   = 1'b0;
        ph_clr = 1'b1;
        if (start_i) begin
          map_clr = 1'b1;
          addr_d  = ADDR_W'(1);
          state_d = SW_GAP;
        end
      end
      SW_GAP: begin
        if (!(ck_s && dt_s)) begin
          ph_clr = 1'b1;
        end else if (ph_cnt == GAP_END) begin
          ph_clr = 1'b1;
          if (addr_q == '0) begin
            state_d = SW_IDLE;
            done_d  = 1'b1;
          end else begin
            state_d = SW_START;
            dt_d    = 1'b1;
          end
        end
      end
      SW_START: begin
        if (ph_cnt == HALF_END) begin
          ph_clr  = 1'b1;
          ck_d    = 1'b1;
          bit_d   = '0;
          state_d = SW_LOW;
        end
      end
      SW_LOW: begin
        if (ph_cnt == HALF_MID)
          dt_d = (bit_q == ACK_BIT) ? 1'b0 : ~tx_byte[3'd7 - bit_q[2:0]];
        if (ph_cnt == HALF_END) begin
          ph_clr  = 1'b1;
          st_clr  = 1'b1;
          ck_d    = 1'b0;
          state_d = SW_HIGH;
        end
      end
      SW_HIGH: begin
        if (!ck_s) begin
          ph_clr = 1'b1;
          abort  = (st_cnt == STR_END);
        end else if (ph_cnt == HALF_END) begin
          ph_clr = 1'b1;
          ck_d   = 1'b1;
          if (bit_q == ACK_BIT) begin
            hit     = !dt_s;
            state_d = SW_STOP_LOW;
          end else begin
            bit_d   = bit_q + 1'b1;
            state_d = SW_LOW;
          end
        end
      end
      SW_STOP_LOW: begin
        if (ph_cnt == HALF_MID) dt_d = 1'b1;
        if (ph_cnt == HALF_END) begin
          ph_clr  = 1'b1;
          st_clr  = 1'b1;
          ck_d    = 1'b0;
          state_d = SW_STOP_HIGH;
        end
      end
      SW_STOP_HIGH: begin
        if (!ck_s) begin
          ph_clr = 1'b1;
          abort  = (st_cnt == STR_END);
        end else if (ph_cnt == HALF_END) begin
          ph_clr  = 1'b1;
          dt_d    = 1'b0;
          addr_d  = addr_q + 1'b1;
          state_d = SW_GAP;
        end
      end
      default: state_d = SW_IDLE;
    endcase
    if (abort) begin
      ph_clr  = 1'b1;
      ck_d    = 1'b0;
      dt_d    = 1'b0;
      addr_d  = addr_q + 1'b1;
      state_d = SW_GAP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SW_IDLE;
      addr_q  <= '0;
      bit_q   <= '0;
      ck_q    <= 1'b0;
      dt_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      bit_q   <= bit_d;
      ck_q    <= ck_d;
      dt_q    <= dt_d;
      done_q  <= done_d;
    end
  end

  assign hit_idx  = addr_q;
  assign ck_low_o = ck_q;
  assign dt_low_o = dt_q;
  assign busy_o   = (state_q != SW_IDLE);
  assign done_o   = done_q;
endmodule

// File: rtl/i2c_addr_sweeper.sv
module i2c_addr_sweeper
  import i2c_sweep_pkg::*;
#(
  parameter int unsigned HALF_CYC    = 625,
  parameter int unsigned STRETCH_MAX = 12500,
  parameter int unsigned GAP_CYC     = 1250,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [MAP_W-1:0]   present_o,
  output logic [ADDR_W-1:0]  found_o,
  input  logic               clk_line_i,
  output logic               clk_line_low_o,
  input  logic               dat_line_i,
  output logic               dat_line_low_o
);
  localparam int unsigned MAX_HS = (HALF_CYC > STRETCH_MAX) ? HALF_CYC : STRETCH_MAX;
  localparam int unsigned MAX_V  = (MAX_HS > 2 * GAP_CYC) ? MAX_HS : 2 * GAP_CYC;
  localparam int unsigned TW     = $clog2(MAX_V + 1);

  logic              rst_core_n;
  logic              ck_s, dt_s;
  logic              ph_clr, st_clr, st_en;
  logic [TW-1:0]     ph_cnt, st_cnt;
  logic              map_clr, hit;
  logic [ADDR_W-1:0] hit_idx;

  sweep_sync #(.STAGES(2), .RESET_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_core_n)
  );

  sweep_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_ck_sync (
    .clk(clk), .rst_n(rst_core_n), .d(clk_line_i), .q(ck_s)
  );

  sweep_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_dt_sync (
    .clk(clk), .rst_n(rst_core_n), .d(dat_line_i), .q(dt_s)
  );

  sweep_cnt #(.W(TW)) u_phase_cnt (
    .clk(clk), .rst_n(rst_core_n), .clr(ph_clr), .en(1'b1), .q(ph_cnt)
  );

  sweep_cnt #(.W(TW)) u_stretch_cnt (
    .clk(clk), .rst_n(rst_core_n), .clr(st_clr), .en(st_en), .q(st_cnt)
  );

  sweep_fsm #(
    .HALF_CYC(HALF_CYC), .STRETCH_MAX(STRETCH_MAX), .GAP_CYC(GAP_CYC), .TW(TW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_core_n), .start_i(start_i),
    .ck_s(ck_s), .dt_s(dt_s), .ph_cnt(ph_cnt), .st_cnt(st_cnt),
    .ph_clr(ph_clr), .st_clr(st_clr), .st_en(st_en),
    .map_clr(map_clr), .hit(hit), .hit_idx(hit_idx),
    .ck_low_o(clk_line_low_o), .dt_low_o(dat_line_low_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  sweep_presence u_map (
    .clk(clk), .rst_n(rst_core_n), .clear(map_clr), .set(hit),
    .idx(hit_idx), .map_q(present_o), .cnt_q(found_o)
  );
endmodule

// File: rtl/i2c_addr_sweeper_checker.sv
module i2c_addr_sweeper_checker (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [127:0] present_o,
  input logic [6:0]   found_o,
  input logic         clk_line_low_o,
  input logic         dat_line_low_o
);
  p_clear_on_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (present_o == '0 && found_o == 7'd0));

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o) |=> (found_o >= $past(found_o)));

  p_done_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  p_busy_falls_at_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  p_count_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |->
      (found_o == $past(found_o) || found_o == $past(found_o) + 7'd1));

  p_lines_free_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!clk_line_low_o && !dat_line_low_o));
endmodule

bind i2c_addr_sweeper i2c_addr_sweeper_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .present_o(present_o), .found_o(found_o),
  .clk_line_low_o(clk_line_low_o), .dat_line_low_o(dat_line_low_o)
);

// File: tb/i2c_addr_sweeper_tb_top.sv
`timescale 1ns/1ps
module i2c_addr_sweeper_tb_top;
  localparam int unsigned HALF = 6;
  localparam int unsigned STRM = 64;
  localparam int unsigned GAP  = 16;
  localparam int unsigned GAP_EFF = (GAP < 2 * HALF) ? 2 * HALF : GAP;
  localparam int unsigned TO_HOLD = 200;
  localparam int unsigned NV = 4;

  typedef struct packed {
    logic [127:0] dev;
    logic [6:0]   str_addr;
    logic [7:0]   str_len;
    logic [6:0]   to_addr;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{(128'd1 << 8'h50) | (128'd1 << 8'h68) | 128'd1, 7'h50, 8'd30, 7'h00},
    '{128'd0,                                         7'h33, 8'd25, 7'h00},
    '{{128{1'b1}},                                    7'h7F, 8'd20, 7'h22},
    '{{64{2'b01}},                                    7'h01, 8'd20, 7'h7F}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_n, start;
  logic         busy, done, ck_low, dt_low;
  logic [127:0] present;
  logic [6:0]   found;
  logic         hold = 1'b0;
  logic         ack_drv = 1'b0;
  wire          ck_bus = ~(ck_low | hold);
  wire          dt_bus = ~(dt_low | ack_drv);

  i2c_addr_sweeper #(.HALF_CYC(HALF), .STRETCH_MAX(STRM), .GAP_CYC(GAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy), .done_o(done),
    .present_o(present), .found_o(found),
    .clk_line_i(ck_bus), .clk_line_low_o(ck_low),
    .dat_line_i(dt_bus), .dat_line_low_o(dt_low)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // slave model and bus monitor
  logic [127:0] cur_dev = '0;
  logic [6:0]   cur_str = '0, cur_to = '0;
  int           cur_len = 0;
  logic         mon_clr = 1'b1;
  logic         p_ck, p_dt, active, drop;
  logic [3:0]   bitcnt;
  logic [7:0]   shreg;
  int hold_cnt, starts, stops, viol, seq_err, next_addr, extra, gap_cnt, min_gap;
  bit gap_run;

  always @(negedge clk) begin
    if (mon_clr) begin
      p_ck = 1'b1; p_dt = 1'b1; active = 1'b0; drop = 1'b0;
      bitcnt = '0; shreg = '0; hold_cnt = 0; hold = 1'b0; ack_drv = 1'b0;
      starts = 0; stops = 0; viol = 0; seq_err = 0; next_addr = 1; extra = 0;
      gap_cnt = 0; gap_run = 0; min_gap = 1 << 30;
    end else begin
      if (hold_cnt > 0) begin
        hold_cnt--;
        if (hold_cnt == 0) begin
          hold = 1'b0;
          if (drop) begin active = 1'b0; ack_drv = 1'b0; bitcnt = '0; drop = 1'b0; end
        end
      end
      if (gap_run) gap_cnt++;
      if (p_ck && ck_bus && (p_dt != dt_bus) && active && bitcnt >= 1 && bitcnt <= 9) viol++;
      if (p_ck && ck_bus && p_dt && !dt_bus) begin
        starts++; active = 1'b1; bitcnt = '0; shreg = '0;
        if (gap_run) begin
          if (gap_cnt < min_gap) min_gap = gap_cnt;
          gap_run = 0;
        end
      end else if (p_ck && ck_bus && !p_dt && dt_bus) begin
        stops++; active = 1'b0; gap_run = 1; gap_cnt = 0;
      end else if (!p_ck && ck_bus && active) begin
        if (bitcnt < 8) shreg = {shreg[6:0], dt_bus};
        if (bitcnt == 7) begin
          if (shreg != {next_addr[6:0], 1'b0}) seq_err++;
          next_addr++;
        end
        if (bitcnt >= 10) extra++;
        else bitcnt = bitcnt + 1'b1;
      end else if (p_ck && !ck_bus && active) begin
        if (bitcnt == 8) begin
          if (cur_dev[shreg[7:1]] && !shreg[0]) ack_drv = 1'b1;
          if (shreg[7:1] == cur_str) begin hold = 1'b1; hold_cnt = cur_len; end
          if (cur_to != 0 && shreg[7:1] == cur_to) begin
            hold = 1'b1; hold_cnt = TO_HOLD; drop = 1'b1;
          end
        end else if (bitcnt == 9) begin
          ack_drv = 1'b0;
        end
      end
      p_ck = ck_bus;
      p_dt = dt_bus;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 195000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !ck_low && !dt_low && present == '0 && found == 0,
        "R12 outputs in reset", {busy, done, ck_low, dt_low}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !ck_low && !dt_low && present == '0 && found == 0,
        "R12 outputs after reset", {busy, done, ck_low, dt_low, found}, 0);

    for (int v = 0; v < NV; v++) begin
      logic [127:0] exp_map, snap;
      int exp_cnt, busy_drop, dones;
      bit seen;
      exp_map = VEC[v].dev & ~128'd1;
      if (VEC[v].to_addr != 0) exp_map[VEC[v].to_addr] = 1'b0;
      exp_cnt = $countones(exp_map);
      cur_dev = VEC[v].dev; cur_str = VEC[v].str_addr;
      cur_len = int'(VEC[v].str_len); cur_to = VEC[v].to_addr;
      mon_clr = 1'b1; @(negedge clk); mon_clr = 1'b0;
      start = 1'b1; @(negedge clk); start = 1'b0;
      chk(busy && present == '0 && found == 0, "R8 accept clears map", present, 0);
      repeat (300) @(negedge clk);
      snap = present;
      start = 1'b1; @(negedge clk); start = 1'b0;
      chk(busy && ((present & snap) == snap), "R9 start while busy ignored", present, snap);
      busy_drop = 0; dones = 0; seen = 0;
      for (int k = 0; k < 40000 && !seen; k++) begin
        @(negedge clk);
        if (done) seen = 1;
        else if (!busy) busy_drop++;
      end
      chk(seen, "R10 done pulse arrives", seen, 1);
      chk(!busy, "R10 busy low with done", busy, 0);
      chk(busy_drop == 0, "R10 busy held through sweep", busy_drop, 0);
      chk(present == exp_map, "R3 presence map", present, exp_map);
      chk(present[0] == 1'b0, "R1 address 0 never present", present[0], 0);
      chk(found == 7'(exp_cnt), "R11 found count", found, exp_cnt);
      chk(present[VEC[v].str_addr] == exp_map[VEC[v].str_addr], "R5 stretched probe",
          present[VEC[v].str_addr], exp_map[VEC[v].str_addr]);
      if (VEC[v].to_addr != 0)
        chk(present[VEC[v].to_addr] == 1'b0, "R6 timed-out address absent",
            present[VEC[v].to_addr], 0);
      chk(starts == 127, "R1 one START per address", starts, 127);
      chk(next_addr == 128 && seq_err == 0, "R1 ascending write-address order",
          {next_addr, seq_err}, {32'd128, 32'd0});
      chk(stops == 127 - int'(VEC[v].to_addr != 0), "R2 STOP per completed probe",
          stops, 127 - int'(VEC[v].to_addr != 0));
      chk(extra == 0, "R2 no clocks after acknowledge", extra, 0);
      chk(viol == 0, "R4 data stable while clock high", viol, 0);
      chk(min_gap >= int'(GAP_EFF), "R7 idle gap", min_gap, GAP_EFF);
      @(negedge clk);
      chk(!done, "R10 done lasts one cycle", done, 0);
      repeat (5) @(negedge clk);
    end

    // reset during a sweep
    cur_dev = {128{1'b1}}; cur_str = '0; cur_len = 0; cur_to = '0;
    mon_clr = 1'b1; @(negedge clk); mon_clr = 1'b0;
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (600) @(negedge clk);
    chk(busy && present != '0, "R3 devices found before reset", present, 1);
    rst_n = 1'b0; mon_clr = 1'b1;
    @(negedge clk);
    chk(!busy && !ck_low && !dt_low && present == '0 && found == 0 && !done,
        "R12 mid-sweep reset", {busy, ck_low, dt_low, found}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !ck_low && !dt_low, "R12 idle after reset release", {busy, ck_low, dt_low}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule